// File: doc/BRIEF.md
# Sequenced Flash Read-Mode Control Register

This block is an 8-bit control register on the CPU register bus. It holds two power-saving enables for flash reads: a slow read mode and a low-current read mode that builds on top of it. Hardware enforces the safe way of driving these enables. Software cannot simply write them.

Each enable can only be raised by a two-write unlock. The first write leaves the bit at 0, and the very next register write sets it to 1. Any interrupt or DMA activity in between breaks the unlock.

The two modes are nested. Low-current mode needs slow mode underneath it, and slow mode cannot be dropped while low-current mode is still on. Entry into each mode is also gated by the present clock conditions:
- Slow mode needs the bus clock at or below its slow limit.
- Low-current mode needs the sub clock selected as CPU clock and the flash not stopped.

A write that breaks any rule is discarded and raises a sticky error flag. Reading the register clears that flag.

Top module: `flash_rdmode_ctl`

## Requirements
- R1: After a synchronous active-high reset, both mode enables, the unlock state and the error flag are 0.
- R2: A read at register address 0x222 returns slow mode in bit 2 and low-current mode in bit 3, with all other bits 0. At any other address the read data is 0.
- R3: A bit (bit 2 slow, bit 3 low-current) goes from 0 to 1 only when the previous register write wrote 0 to that same bit and was accepted. A set attempt without that unlock is rejected.
- R4: Interrupt/DMA activity disarms any pending unlock, in any cycle from the arming write up to and including the setting write. A set that needs the disarmed unlock is then rejected.
- R5: Setting bit 3 needs bit 2 already 1. Clearing bit 2 needs bit 3 already 0. Otherwise the write is rejected.
- R6: A write that would change both bit 2 and bit 3 is rejected.
- R7: Setting bit 2 is rejected unless the bus-clock-slow flag is 1.
- R8: Setting bit 3 is rejected unless the sub-clock flag is 1 and the flash-stop flag is 0.
- R9: A rejected write leaves the register unchanged and sets the error flag. A read of the register clears the flag, except that a rejection in the same cycle wins.
- R10: The enables change only on the clock edge after an accepted write. A clearing write needs no unlock and no interlock.
- R11: A write to any other address leaves the register unchanged and disarms any pending unlock.
- R12: A write with bit 1 or bit 0 set is rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Register bus byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| clk_slow_ok | input | 1 | Bus clock is at or below the slow-read limit |
| subclk_sel | input | 1 | Sub clock drives the CPU |
| flash_stop | input | 1 | Flash is stopped |
| irq_dma_busy | input | 1 | Interrupt or DMA activity this cycle |
| slow_rd_en | output | 1 | Slow read mode enable |
| lowcur_rd_en | output | 1 | Low-current read mode enable |
| seq_err | output | 1 | Sticky rule-violation flag |

## Verification
The two enables and the error flag are registered. Their new values are due one cycle after the write or read strobe is sampled, and the read data is due in the same cycle as the read address. The bench drives each access on a falling edge and removes it on the next falling edge, with one rising edge in between. It samples the registered outputs at that second falling edge and the read data one time unit after the address is applied, so every sample lands exactly one register stage after its stimulus. Idle cycles and interrupt pulses are placed between the arming and setting writes to show that only bus writes and interrupt activity consume the unlock.

// File: rtl/frm_pkg.sv
package frm_pkg;
    localparam int SLOW_BIT = 2;
    localparam int LC_BIT   = 3;

    typedef struct packed {
        logic slow;
        logic lowcur;
        logic arm_slow;
        logic arm_lc;
        logic err;
    } frm_state_t;
endpackage

// File: rtl/frm_bus_decode.sv
module frm_bus_decode #(
    parameter int              ADDR_W   = 16,
    parameter int              DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0222
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              slow_q,
    input  logic              lowcur_q,
    output logic              wr_hit,
    output logic              wr_other,
    output logic              rd_hit,
    output logic [DATA_W-1:0] rdata
);
    logic match;

    assign match    = (bus_addr == REG_ADDR);
    assign wr_hit   = bus_wr & match;
    assign wr_other = bus_wr & ~match;
    assign rd_hit   = bus_rd & match;

    always_comb begin
        rdata = '0;
        if (match) begin
            rdata[frm_pkg::SLOW_BIT] = slow_q;
            rdata[frm_pkg::LC_BIT]   = lowcur_q;
        end
    end
endmodule

// File: rtl/frm_unlock_bit.sv
module frm_unlock_bit (
    input  logic arm_q,
    input  logic wr_hit,
    input  logic wr_other,
    input  logic accept,
    input  logic wr_val,
    input  logic irq_dma_busy,
    output logic arm_d
);
    always_comb begin
        if (irq_dma_busy)
            arm_d = 1'b0;
        else if (wr_hit)
            arm_d = accept & ~wr_val;
        else if (wr_other)
            arm_d = 1'b0;
        else
            arm_d = arm_q;
    end
endmodule

// File: rtl/frm_rule_check.sv
module frm_rule_check (
    input  logic new_slow,
    input  logic new_lc,
    input  logic rsvd_set,
    input  logic slow_q,
    input  logic lowcur_q,
    input  logic arm_slow_q,
    input  logic arm_lc_q,
    input  logic clk_slow_ok,
    input  logic subclk_sel,
    input  logic flash_stop,
    input  logic irq_dma_busy,
    output logic accept
);
    logic chg_slow;
    logic chg_lc;
    logic viol;

    assign chg_slow = new_slow ^ slow_q;
    assign chg_lc   = new_lc ^ lowcur_q;

    always_comb begin
        viol = 1'b0;
        if (rsvd_set) begin
            viol = 1'b1;
        end else if (chg_slow && chg_lc) begin
            viol = 1'b1;
        end else if (chg_slow) begin
            if (new_slow)
                viol = ~arm_slow_q | ~clk_slow_ok | irq_dma_busy;
            else
                viol = lowcur_q;
        end else if (chg_lc) begin
            if (new_lc)
                viol = ~arm_lc_q | ~slow_q | ~subclk_sel | flash_stop | irq_dma_busy;
        end
        accept = ~viol;
    end
endmodule

// File: rtl/flash_rdmode_ctl.sv
module flash_rdmode_ctl #(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0222
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              clk_slow_ok,
    input  logic              subclk_sel,
    input  logic              flash_stop,
    input  logic              irq_dma_busy,
    output logic              slow_rd_en,
    output logic              lowcur_rd_en,
    output logic              seq_err
);
    import frm_pkg::*;

    localparam int NUM_MODES = 2;
    localparam int RSVD_W    = SLOW_BIT;
    localparam int UPPER_LO  = LC_BIT + 1;

    frm_state_t st_q, st_d;

    logic wr_hit, wr_other, rd_hit, accept, rsvd_set;
    logic [NUM_MODES-1:0] arm_q_vec, arm_d_vec, new_vec;
    logic unused_upper;

    assign new_vec      = {bus_wdata[LC_BIT], bus_wdata[SLOW_BIT]};
    assign arm_q_vec    = {st_q.arm_lc, st_q.arm_slow};
    assign rsvd_set     = |bus_wdata[RSVD_W-1:0];
    assign unused_upper = ^bus_wdata[DATA_W-1:UPPER_LO];

    frm_bus_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .REG_ADDR (REG_ADDR)
    ) u_dec (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .slow_q   (st_q.slow),
        .lowcur_q (st_q.lowcur),
        .wr_hit   (wr_hit),
        .wr_other (wr_other),
        .rd_hit   (rd_hit),
        .rdata    (bus_rdata)
    );

    frm_rule_check u_rules (
        .new_slow     (new_vec[0]),
        .new_lc       (new_vec[1]),
        .rsvd_set     (rsvd_set),
        .slow_q       (st_q.slow),
        .lowcur_q     (st_q.lowcur),
        .arm_slow_q   (st_q.arm_slow),
        .arm_lc_q     (st_q.arm_lc),
        .clk_slow_ok  (clk_slow_ok),
        .subclk_sel   (subclk_sel),
        .flash_stop   (flash_stop),
        .irq_dma_busy (irq_dma_busy),
        .accept       (accept)
    );

    for (genvar g = 0; g < NUM_MODES; g++) begin : g_unlock
        frm_unlock_bit u_unlock (
            .arm_q        (arm_q_vec[g]),
            .wr_hit       (wr_hit),
            .wr_other     (wr_other),
            .accept       (accept),
            .wr_val       (new_vec[g]),
            .irq_dma_busy (irq_dma_busy),
            .arm_d        (arm_d_vec[g])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.arm_slow = arm_d_vec[0];
        st_d.arm_lc   = arm_d_vec[1];
        if (wr_hit && accept) begin
            st_d.slow   = new_vec[0];
            st_d.lowcur = new_vec[1];
        end
        if (wr_hit && !accept)
            st_d.err = 1'b1;
        else if (rd_hit)
            st_d.err = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign slow_rd_en   = st_q.slow;
    assign lowcur_rd_en = st_q.lowcur;
    assign seq_err      = st_q.err;
endmodule

// File: rtl/frm_rdmode_checker.sv
module frm_rdmode_checker #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0222
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              clk_slow_ok,
    input logic              subclk_sel,
    input logic              flash_stop,
    input logic              irq_dma_busy,
    input logic              slow_rd_en,
    input logic              lowcur_rd_en,
    input logic              seq_err
);
    logic wr_here, rd_here;
    assign wr_here = bus_wr && (bus_addr == REG_ADDR);
    assign rd_here = bus_rd && (bus_addr == REG_ADDR);

    p_lc_needs_slow_r5: assert property (@(posedge clk) disable iff (rst)
        lowcur_rd_en |-> slow_rd_en);

    p_slow_rise_gate_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(slow_rd_en) |-> ($past(clk_slow_ok) && $past(wr_here)));

    p_no_irq_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(slow_rd_en) || $rose(lowcur_rd_en)) |-> !$past(irq_dma_busy));

    p_lc_rise_gate_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(lowcur_rd_en) |-> ($past(subclk_sel) && !$past(flash_stop) && $past(slow_rd_en)));

    p_one_bit_moves_r6: assert property (@(posedge clk) disable iff (rst)
        !(!$stable(slow_rd_en) && !$stable(lowcur_rd_en)));

    p_hold_without_write_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_here) |-> ($stable(slow_rd_en) && $stable(lowcur_rd_en)));

    p_err_read_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_here && !wr_here) |=> !seq_err);

    p_err_from_write_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(seq_err) |-> $past(wr_here));
endmodule

bind flash_rdmode_ctl frm_rdmode_checker #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .clk_slow_ok  (clk_slow_ok),
    .subclk_sel   (subclk_sel),
    .flash_stop   (flash_stop),
    .irq_dma_busy (irq_dma_busy),
    .slow_rd_en   (slow_rd_en),
    .lowcur_rd_en (lowcur_rd_en),
    .seq_err      (seq_err)
);

// File: tb/flash_rdmode_ctl_bench.sv
`timescale 1ns/1ps
module flash_rdmode_ctl_bench;
    localparam logic [15:0] RA = 16'h0222;

    logic clk = 1'b0;
    logic rst;
    logic [15:0] bus_addr;
    logic bus_wr, bus_rd;
    logic [7:0] bus_wdata, bus_rdata;
    logic clk_slow_ok, subclk_sel, flash_stop, irq_dma_busy;
    logic slow_rd_en, lowcur_rd_en, seq_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    flash_rdmode_ctl u_flash_rdmode_ctl (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_slow_ok(clk_slow_ok),
        .subclk_sel(subclk_sel), .flash_stop(flash_stop), .irq_dma_busy(irq_dma_busy),
        .slow_rd_en(slow_rd_en), .lowcur_rd_en(lowcur_rd_en), .seq_err(seq_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req, input logic s, input logic l, input logic e);
        check(slow_rd_en === s, {req, " slow"}, int'(slow_rd_en), int'(s));
        check(lowcur_rd_en === l, {req, " lowcur"}, int'(lowcur_rd_en), int'(l));
        check(seq_err === e, {req, " err"}, int'(seq_err), int'(e));
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [7:0] d, input logic with_rd = 1'b0);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = with_rd;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic do_rd(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic clear_err(input string req);
        logic [7:0] v;
        do_rd(RA, v);
        check(seq_err === 1'b0, {req, " err cleared by read"}, int'(seq_err), 0);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check_state("R1 reset", 1'b0, 1'b0, 1'b0);
        do_rd(RA, v);
        check(v === 8'h00, "R2 reset readback", int'(v), 0);
    endtask

    task automatic t_no_unlock;
        logic [7:0] v;
        do_wr(RA, 8'h04);
        check_state("R3 set without unlock", 1'b0, 1'b0, 1'b1);
        do_rd(RA, v);
        check(v === 8'h00, "R2 readback after reject", int'(v), 0);
        check(seq_err === 1'b0, "R9 read clears err", int'(seq_err), 0);
    endtask

    task automatic t_lc_before_slow;
        do_wr(RA, 8'h00);
        do_wr(RA, 8'h08);
        check_state("R5 lowcur without slow", 1'b0, 1'b0, 1'b1);
        clear_err("R9");
    endtask

    task automatic t_both_change;
        do_wr(RA, 8'h00);
        do_wr(RA, 8'h0C);
        check_state("R6 both bits change", 1'b0, 1'b0, 1'b1);
        clear_err("R9");
    endtask

    task automatic t_clock_gate;
        clk_slow_ok = 1'b0;
        do_wr(RA, 8'h00);
        do_wr(RA, 8'h04);
        check_state("R7 fast clock blocks slow", 1'b0, 1'b0, 1'b1);
        clk_slow_ok = 1'b1;
        clear_err("R9");
    endtask

    task automatic t_irq_breaks;
        do_wr(RA, 8'h00);
        @(negedge clk); irq_dma_busy = 1'b1;
        @(negedge clk); irq_dma_busy = 1'b0;
        do_wr(RA, 8'h04);
        check_state("R4 irq between writes", 1'b0, 1'b0, 1'b1);
        clear_err("R9");
        do_wr(RA, 8'h00);
        irq_dma_busy = 1'b1;
        do_wr(RA, 8'h04);
        irq_dma_busy = 1'b0;
        check_state("R4 irq on setting write", 1'b0, 1'b0, 1'b1);
        clear_err("R9");
    endtask

    task automatic t_other_addr;
        logic [7:0] v;
        do_wr(RA, 8'h00);
        do_wr(RA + 16'h1, 8'h04);
        check_state("R11 foreign write no effect", 1'b0, 1'b0, 1'b0);
        do_wr(RA, 8'h04);
        check_state("R11 foreign write disarms", 1'b0, 1'b0, 1'b1);
        clear_err("R9");
        do_rd(RA + 16'h1, v);
        check(v === 8'h00, "R2 other address reads 0", int'(v), 0);
    endtask

    task automatic t_reserved;
        do_wr(RA, 8'h00);
        do_wr(RA, 8'h05);
        check_state("R12 reserved bit set", 1'b0, 1'b0, 1'b1);
        clear_err("R9");
    endtask

    task automatic t_enter_slow;
        logic [7:0] v;
        do_wr(RA, 8'h00);
        check_state("R10 arming write keeps slow 0", 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        do_wr(RA, 8'h04);
        check_state("R3 unlocked slow set", 1'b1, 1'b0, 1'b0);
        do_rd(RA, v);
        check(v === 8'h04, "R2 readback slow", int'(v), 4);
    endtask

    task automatic t_enter_lowcur;
        logic [7:0] v;
        subclk_sel = 1'b0;
        do_wr(RA, 8'h04);
        do_wr(RA, 8'h0C);
        check_state("R8 no sub clock", 1'b1, 1'b0, 1'b1);
        clear_err("R9");
        subclk_sel = 1'b1; flash_stop = 1'b1;
        do_wr(RA, 8'h04);
        do_wr(RA, 8'h0C);
        check_state("R8 flash stopped", 1'b1, 1'b0, 1'b1);
        clear_err("R9");
        flash_stop = 1'b0;
        do_wr(RA, 8'h04);
        do_wr(RA, 8'h0C);
        check_state("R8 lowcur set", 1'b1, 1'b1, 1'b0);
        do_rd(RA, v);
        check(v === 8'h0C, "R2 readback both", int'(v), 12);
    endtask

    task automatic t_leave;
        do_wr(RA, 8'h08, 1'b1);
        check_state("R5 slow clear under lowcur, R9 set wins over read", 1'b1, 1'b1, 1'b1);
        clear_err("R9");
        clk_slow_ok = 1'b0; subclk_sel = 1'b0;
        do_wr(RA, 8'h04);
        check_state("R10 lowcur clear needs nothing", 1'b1, 1'b0, 1'b0);
        do_wr(RA, 8'h00);
        check_state("R10 slow clear needs nothing", 1'b0, 1'b0, 1'b0);
        clk_slow_ok = 1'b1; subclk_sel = 1'b1;
    endtask

    initial begin
        rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
        clk_slow_ok = 1'b1; subclk_sel = 1'b1; flash_stop = 1'b0; irq_dma_busy = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_no_unlock();
        t_lc_before_slow();
        t_both_change();
        t_clock_gate();
        t_irq_breaks();
        t_other_addr();
        t_reserved();
        t_enter_slow();
        t_enter_lowcur();
        t_leave();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule